// File: doc/BRIEF.md
# SMBus host control and status register block

This block is the software-facing register file of an SMBus host controller. A processor reaches it over a simple byte-wide register bus with an address, a write strobe, a read strobe and write and read data. The block holds the settings for one transaction: target address, command byte, two data bytes, protocol code, PEC enable and auxiliary mode bits. It also holds a start request and an abort request, and it passes all of these to a separate transaction engine.

The engine reports back through single-cycle event inputs: byte finished, transaction finished, device did not acknowledge, and arbitration lost. The block turns these events into sticky status flags. Software clears each flag by writing a 1 to its bit. The block drives a busy output. It also drives one interrupt line, which software can mask.

A transaction begins when software writes the control byte with its start bit set while the host is idle. It ends on a completion or error event, or when software aborts it through the kill bit. Reads return data combinationally in the cycle in which the read strobe is high.

Top module: `smb_host_regs`

## Requirements
- R1: After synchronous reset, every register reads 0x00, and busy, irq, eng_start and eng_kill are all low.
- R2: The command byte (offset 3), the slave address byte (offset 4), data byte 0 (offset 5) and data byte 1 (offset 6) each read back the last value written and drive the matching eng_* output. In the auxiliary control byte (offset 13), bit 0 is the CRC enable and bit 1 is the 32-byte buffer enable; both are writable, and bits 7:2 read 0.
- R3: A write to the control byte (offset 2) with bit 6 set, issued while idle, sets busy and pulses eng_start for exactly one cycle. Both take effect at the clock edge that captures the write. Control reads back bit 7 = PEC enable, bit 6 = 0 always, bits 5:2 = protocol code (bit 5 marks the last byte), bit 1 = kill and bit 0 = interrupt enable.
- R4: A start request is ignored when busy is set, or when the same write also sets the kill bit (bit 1). While busy, a control write updates only the kill and interrupt-enable bits; the PEC and protocol fields keep their values.
- R5: eng_done while busy sets status bit 1 (completion) and clears busy (status bit 0) on the same edge.
- R6: eng_dev_err while busy sets status bit 2 and clears busy. eng_bus_err while busy sets status bit 3 and clears busy.
- R7: eng_byte_done while busy sets status bit 7 and leaves busy set.
- R8: Engine event inputs that arrive while busy is low do not change the status byte.
- R9: A control write with bit 1 set while busy sets status bit 4 (failed) and clears busy at the next edge. eng_kill follows the stored kill bit. The same write while idle leaves status unchanged.
- R10: A write to the status byte (offset 0) clears each of bits 7, 4, 3, 2 and 1 that has a 1 in the write data. Busy and the other bits are unaffected by such a write. A flag set by an event wins over a clear in the same cycle.
- R11: irq is high exactly when control bit 0 is set and at least one of status bits 1, 2, 3 or 4 is set. Status bit 7 alone does not raise irq.
- R12: With reg_rd low, reg_rdata is 0x00. Offsets that have no register (7, 8, 12 and others) read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_rd is high |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_kill | output | 1 | Abort request level to the engine |
| eng_proto | output | 4 | Protocol code with last-byte marker |
| eng_pec_en | output | 1 | PEC enable |
| eng_cmd | output | 8 | Command byte |
| eng_slave | output | 8 | Slave address byte |
| eng_data0 | output | 8 | Data byte 0 |
| eng_data1 | output | 8 | Data byte 1 |
| eng_aux_crc | output | 1 | Hardware CRC enable |
| eng_aux_blkbuf | output | 1 | 32-byte buffer mode enable |
| eng_byte_done | input | 1 | Engine event: one byte finished |
| eng_done | input | 1 | Engine event: transaction finished |
| eng_dev_err | input | 1 | Engine event: no acknowledge |
| eng_bus_err | input | 1 | Engine event: arbitration lost |
| busy | output | 1 | Host busy |
| irq | output | 1 | Masked interrupt |

## Verification
The bound checker watches the busy handshake on every cycle. It confirms that a start pulse occurs only together with busy, and that no start follows a busy cycle. It also confirms that each completion, error or kill event sets its flag and drops busy at the next edge, that idle cycles with no write leave the status byte still, and that irq is never high without its enable. The bench scenarios are needed to show the values software sees. These are the field packing of the control readback, the held PEC and protocol fields during a refused start, write-1-to-clear on chosen bits, the set-over-clear collision, and the zero reads of unmapped offsets.

// File: rtl/smb_regs_pkg.sv
package smb_regs_pkg;

    localparam int OFS_STS    = 0;
    localparam int OFS_CTL    = 2;
    localparam int PLAIN_BASE = 3;   // command, slave, data0, data1 follow
    localparam int NUM_PLAIN  = 4;
    localparam int OFS_AUX    = 13;
    localparam int AUX_BITS   = 2;

    localparam logic [7:0] CLR_MASK = 8'h9E;

    typedef struct packed {
        logic byte_done;
        logic in_use;
        logic alert;
        logic failed;
        logic bus_err;
        logic dev_err;
        logic intr;
        logic busy;
    } sts_t;

    typedef struct packed {
        logic       pec;
        logic       start;
        logic [3:0] proto;
        logic       kill;
        logic       ie;
    } ctl_t;

    function automatic logic irq_cause(input sts_t s);
        return s.intr | s.dev_err | s.bus_err | s.failed;
    endfunction

endpackage

// File: rtl/smb_ctrl_unit.sv
module smb_ctrl_unit
    import smb_regs_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_ctl,
    input  logic                      wr_aux,
    input  logic [NUM_PLAIN-1:0]      wr_plain,
    input  logic [7:0]                wdata,
    input  logic                      busy,
    output ctl_t                      ctl_q,
    output logic [NUM_PLAIN-1:0][7:0] plain_q,
    output logic [AUX_BITS-1:0]       aux_q,
    output logic                      start_req,
    output logic                      kill_hit,
    output logic                      start_pulse
);

    ctl_t wctl;
    assign wctl = ctl_t'(wdata);

    assign start_req = wr_ctl && wctl.start && !wctl.kill && !busy;
    assign kill_hit  = wr_ctl && wctl.kill && busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q       <= '0;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= start_req;
            ctl_q.start <= 1'b0;
            if (wr_ctl) begin
                ctl_q.ie   <= wctl.ie;
                ctl_q.kill <= wctl.kill;
                if (!busy) begin
                    ctl_q.pec   <= wctl.pec;
                    ctl_q.proto <= wctl.proto;
                end
            end
        end
    end

    for (genvar i = 0; i < NUM_PLAIN; i++) begin : g_plain
        always_ff @(posedge clk) begin
            if (rst)
                plain_q[i] <= '0;
            else if (wr_plain[i])
                plain_q[i] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            aux_q <= '0;
        else if (wr_aux)
            aux_q <= wdata[AUX_BITS-1:0];
    end

endmodule

// File: rtl/smb_status_unit.sv
module smb_status_unit
    import smb_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] clr_mask,
    input  logic       start_req,
    input  logic       kill_hit,
    input  logic       ev_byte,
    input  logic       ev_done,
    input  logic       ev_dev,
    input  logic       ev_bus,
    output sts_t       sts_q
);

    sts_t set_v;
    sts_t sts_d;
    logic finish;

    always_comb begin
        set_v           = '0;
        set_v.byte_done = sts_q.busy && ev_byte;
        set_v.intr      = sts_q.busy && ev_done;
        set_v.dev_err   = sts_q.busy && ev_dev;
        set_v.bus_err   = sts_q.busy && ev_bus;
        set_v.failed    = kill_hit;
        finish          = set_v.intr || set_v.dev_err || set_v.bus_err || kill_hit;

        sts_d      = sts_t'((sts_q & ~clr_mask) | set_v);
        sts_d.busy = start_req ? 1'b1 : (finish ? 1'b0 : sts_q.busy);
    end

    always_ff @(posedge clk) begin
        if (rst)
            sts_q <= '0;
        else
            sts_q <= sts_d;
    end

endmodule

// File: rtl/smb_read_mux.sv
module smb_read_mux
    import smb_regs_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      rd,
    input  sts_t                      sts,
    input  ctl_t                      ctl,
    input  logic [NUM_PLAIN-1:0][7:0] plain,
    input  logic [AUX_BITS-1:0]       aux,
    output logic [7:0]                rdata
);

    always_comb begin
        rdata = '0;
        if (rd) begin
            if (addr == ADDR_W'(OFS_STS))
                rdata = sts;
            else if (addr == ADDR_W'(OFS_CTL))
                rdata = ctl;
            else if (addr == ADDR_W'(OFS_AUX))
                rdata = {{(8-AUX_BITS){1'b0}}, aux};
            for (int i = 0; i < NUM_PLAIN; i++)
                if (addr == ADDR_W'(PLAIN_BASE + i))
                    rdata = plain[i];
        end
    end

endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
    import smb_regs_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              eng_start,
    output logic              eng_kill,
    output logic [3:0]        eng_proto,
    output logic              eng_pec_en,
    output logic [7:0]        eng_cmd,
    output logic [7:0]        eng_slave,
    output logic [7:0]        eng_data0,
    output logic [7:0]        eng_data1,
    output logic              eng_aux_crc,
    output logic              eng_aux_blkbuf,
    input  logic              eng_byte_done,
    input  logic              eng_done,
    input  logic              eng_dev_err,
    input  logic              eng_bus_err,
    output logic              busy,
    output logic              irq
);

    logic                      wr_sts, wr_ctl, wr_aux;
    logic [NUM_PLAIN-1:0]      wr_plain;
    logic [7:0]                clr_mask;
    logic                      start_req, kill_hit;
    ctl_t                      ctl_q;
    sts_t                      sts_q;
    logic [NUM_PLAIN-1:0][7:0] plain_q;
    logic [AUX_BITS-1:0]       aux_q;

    assign wr_sts   = reg_wr && (reg_addr == ADDR_W'(OFS_STS));
    assign wr_ctl   = reg_wr && (reg_addr == ADDR_W'(OFS_CTL));
    assign wr_aux   = reg_wr && (reg_addr == ADDR_W'(OFS_AUX));
    assign clr_mask = wr_sts ? (reg_wdata & CLR_MASK) : 8'h00;

    for (genvar i = 0; i < NUM_PLAIN; i++) begin : g_dec
        assign wr_plain[i] = reg_wr && (reg_addr == ADDR_W'(PLAIN_BASE + i));
    end

    smb_ctrl_unit u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .wr_ctl      (wr_ctl),
        .wr_aux      (wr_aux),
        .wr_plain    (wr_plain),
        .wdata       (reg_wdata),
        .busy        (sts_q.busy),
        .ctl_q       (ctl_q),
        .plain_q     (plain_q),
        .aux_q       (aux_q),
        .start_req   (start_req),
        .kill_hit    (kill_hit),
        .start_pulse (eng_start)
    );

    smb_status_unit u_sts (
        .clk       (clk),
        .rst       (rst),
        .clr_mask  (clr_mask),
        .start_req (start_req),
        .kill_hit  (kill_hit),
        .ev_byte   (eng_byte_done),
        .ev_done   (eng_done),
        .ev_dev    (eng_dev_err),
        .ev_bus    (eng_bus_err),
        .sts_q     (sts_q)
    );

    smb_read_mux #(.ADDR_W(ADDR_W)) u_rmux (
        .addr  (reg_addr),
        .rd    (reg_rd),
        .sts   (sts_q),
        .ctl   (ctl_q),
        .plain (plain_q),
        .aux   (aux_q),
        .rdata (reg_rdata)
    );

    assign busy           = sts_q.busy;
    assign irq            = ctl_q.ie && irq_cause(sts_q);
    assign eng_kill       = ctl_q.kill;
    assign eng_proto      = ctl_q.proto;
    assign eng_pec_en     = ctl_q.pec;
    assign eng_cmd        = plain_q[0];
    assign eng_slave      = plain_q[1];
    assign eng_data0      = plain_q[2];
    assign eng_data1      = plain_q[3];
    assign eng_aux_crc    = aux_q[0];
    assign eng_aux_blkbuf = aux_q[1];

endmodule

// File: rtl/smb_host_regs_chk.sv
module smb_host_regs_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [7:0]        reg_wdata,
    input logic              eng_start,
    input logic              eng_byte_done,
    input logic              eng_done,
    input logic              eng_dev_err,
    input logic              eng_bus_err,
    input logic              busy,
    input logic              irq,
    input logic              kill_hit,
    input logic              ie,
    input logic [7:0]        sts
);

    assert_start_with_busy_R3: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> busy);

    assert_no_start_after_busy_R4: assert property (@(posedge clk) disable iff (rst)
        busy |=> !eng_start);

    assert_done_clears_busy_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && eng_done) |=> (!busy && sts[1]));

    assert_dev_err_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && eng_dev_err) |=> (!busy && sts[2]));

    assert_bus_err_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && eng_bus_err) |=> (!busy && sts[3]));

    assert_byte_keeps_busy_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && eng_byte_done && !eng_done && !eng_dev_err && !eng_bus_err && !kill_hit)
        |=> (busy && sts[7]));

    assert_idle_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !reg_wr) |=> $stable(sts));

    assert_kill_fails_R9: assert property (@(posedge clk) disable iff (rst)
        kill_hit |=> (sts[4] && !busy));

    assert_w1c_intr_R10: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == '0 && reg_wdata[1] && !(busy && eng_done)) |=> !sts[1]);

    assert_irq_gated_R11: assert property (@(posedge clk) disable iff (rst)
        irq |-> ie);

endmodule

bind smb_host_regs smb_host_regs_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_addr      (reg_addr),
    .reg_wr        (reg_wr),
    .reg_wdata     (reg_wdata),
    .eng_start     (eng_start),
    .eng_byte_done (eng_byte_done),
    .eng_done      (eng_done),
    .eng_dev_err   (eng_dev_err),
    .eng_bus_err   (eng_bus_err),
    .busy          (busy),
    .irq           (irq),
    .kill_hit      (kill_hit),
    .ie            (ctl_q.ie),
    .sts           (sts_q)
);

// File: tb/test_smb_host_regs.sv
`timescale 1ns/1ps
module test_smb_host_regs;

    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          eng_start, eng_kill, eng_pec_en, eng_aux_crc, eng_aux_blkbuf;
    logic [3:0]    eng_proto;
    logic [7:0]    eng_cmd, eng_slave, eng_data0, eng_data1;
    logic          eng_byte_done = 1'b0, eng_done = 1'b0, eng_dev_err = 1'b0, eng_bus_err = 1'b0;
    logic          busy, irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [AW-1:0] addr;
        logic [7:0]    exp;
        string         tag;
    } exp_t;
    exp_t sbq[$];

    always #4 clk = ~clk;

    smb_host_regs #(.ADDR_W(AW)) i_smb_host_regs (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_start(eng_start),
        .eng_kill(eng_kill), .eng_proto(eng_proto), .eng_pec_en(eng_pec_en),
        .eng_cmd(eng_cmd), .eng_slave(eng_slave), .eng_data0(eng_data0),
        .eng_data1(eng_data1), .eng_aux_crc(eng_aux_crc), .eng_aux_blkbuf(eng_aux_blkbuf),
        .eng_byte_done(eng_byte_done), .eng_done(eng_done), .eng_dev_err(eng_dev_err),
        .eng_bus_err(eng_bus_err), .busy(busy), .irq(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard while a read is presented
    always @(negedge clk) begin
        if (reg_rd && sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            chk($sformatf("%s rd@%0d", e.tag, e.addr), reg_rdata, e.exp);
        end
    end

    task automatic rd_exp(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        reg_addr = a;
        reg_rd   = 1'b1;
        sbq.push_back('{a, exp, tag});
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(posedge clk); #1;
        case (which)
            0: eng_byte_done = 1'b1;
            1: eng_done      = 1'b1;
            2: eng_dev_err   = 1'b1;
            default: eng_bus_err = 1'b1;
        endcase
        @(posedge clk); #1;
        eng_byte_done = 1'b0; eng_done = 1'b0; eng_dev_err = 1'b0; eng_bus_err = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk("R1 busy", {7'b0, busy}, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 eng_start", {7'b0, eng_start}, 8'h00);
        chk("R1 eng_kill", {7'b0, eng_kill}, 8'h00);
        rd_exp(0, 8'h00, "R1");
        rd_exp(2, 8'h00, "R1");
        rd_exp(5, 8'h00, "R1");
        rd_exp(13, 8'h00, "R1");

        // R2 plain registers and aux
        wr(3, 8'hA5); wr(4, 8'h3C); wr(5, 8'h11); wr(6, 8'hFE);
        rd_exp(3, 8'hA5, "R2"); rd_exp(4, 8'h3C, "R2");
        rd_exp(5, 8'h11, "R2"); rd_exp(6, 8'hFE, "R2");
        chk("R2 eng_cmd", eng_cmd, 8'hA5);
        chk("R2 eng_slave", eng_slave, 8'h3C);
        chk("R2 eng_data1", eng_data1, 8'hFE);
        wr(13, 8'hFF);
        rd_exp(13, 8'h03, "R2");
        chk("R2 aux pins", {6'b0, eng_aux_blkbuf, eng_aux_crc}, 8'h03);

        // R12 unmapped offsets and read strobe low
        rd_exp(7, 8'h00, "R12"); rd_exp(8, 8'h00, "R12"); rd_exp(12, 8'h00, "R12");
        @(posedge clk); #1 reg_addr = 3;
        @(negedge clk) chk("R12 rd low", reg_rdata, 8'h00);

        // R3 start: PEC, word-data protocol, ie
        wr(2, 8'hCD);
        chk("R3 eng_start", {7'b0, eng_start}, 8'h01);
        chk("R3 busy", {7'b0, busy}, 8'h01);
        chk("R3 proto", {4'b0, eng_proto}, 8'h03);
        chk("R3 pec", {7'b0, eng_pec_en}, 8'h01);
        @(posedge clk); #1;
        chk("R3 start one cycle", {7'b0, eng_start}, 8'h00);
        rd_exp(2, 8'h8D, "R3");
        rd_exp(0, 8'h01, "R3");

        // R4 start while busy ignored
        wr(2, 8'h55);
        chk("R4 no start", {7'b0, eng_start}, 8'h00);
        rd_exp(2, 8'h8D, "R4");

        // R7 byte done keeps busy
        pulse(0);
        rd_exp(0, 8'h81, "R7");
        chk("R11 byte done no irq", {7'b0, irq}, 8'h00);

        // R5 completion
        pulse(1);
        rd_exp(0, 8'h82, "R5");
        chk("R5 busy", {7'b0, busy}, 8'h00);
        chk("R11 irq on intr", {7'b0, irq}, 8'h01);

        // R10 write one to clear
        wr(0, 8'h02);
        rd_exp(0, 8'h80, "R10");
        chk("R11 irq cleared", {7'b0, irq}, 8'h00);
        wr(0, 8'hFF);
        rd_exp(0, 8'h00, "R10");

        // R8 events while idle ignored
        pulse(1); pulse(2); pulse(3); pulse(0);
        rd_exp(0, 8'h00, "R8");

        // R6 device error and bus error
        wr(2, 8'h41);
        pulse(2);
        rd_exp(0, 8'h04, "R6");
        chk("R6 busy dev", {7'b0, busy}, 8'h00);
        wr(0, 8'h04);
        wr(2, 8'h41);
        pulse(3);
        rd_exp(0, 8'h08, "R6");
        chk("R6 busy bus", {7'b0, busy}, 8'h00);
        wr(0, 8'h08);

        // R9 kill while busy, then while idle
        wr(2, 8'h41);
        chk("R9 busy before kill", {7'b0, busy}, 8'h01);
        wr(2, 8'h03);
        rd_exp(0, 8'h10, "R9");
        chk("R9 eng_kill", {7'b0, eng_kill}, 8'h01);
        chk("R11 irq failed", {7'b0, irq}, 8'h01);
        wr(2, 8'h01);
        chk("R9 eng_kill low", {7'b0, eng_kill}, 8'h00);
        wr(0, 8'h10);
        wr(2, 8'h03);
        rd_exp(0, 8'h00, "R9");
        wr(2, 8'h01);

        // R4 start together with kill is refused
        wr(2, 8'h42);
        chk("R4 start+kill", {7'b0, busy}, 8'h00);
        wr(2, 8'h00);

        // R11 gating by interrupt enable
        wr(2, 8'h40);
        pulse(1);
        chk("R11 masked", {7'b0, irq}, 8'h00);
        wr(2, 8'h01);
        chk("R11 unmasked", {7'b0, irq}, 8'h01);
        wr(0, 8'h02);

        // R10 set wins over clear in the same cycle
        wr(2, 8'h41);
        @(posedge clk); #1;
        eng_done = 1'b1; reg_wr = 1'b1; reg_addr = 0; reg_wdata = 8'h02;
        @(posedge clk); #1;
        eng_done = 1'b0; reg_wr = 1'b0;
        rd_exp(0, 8'h02, "R10 collision");

        repeat (2) @(posedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule